// File: doc/BRIEF.md
# Fault Event Latch with Service-Request Messaging

This block sits beside a power-supply controller. It watches eight fault condition lines and keeps a sticky event register of the faults that an 8-bit enable mask lets through. Software reads the event register with a read strobe. That read also clears the register, and a clear-status input does the same. Power-up reset clears it as well. Bits set by a fault stay set after the fault goes away, until one of those three clears happens.

The block samples the condition lines every cycle. When any enabled condition bit changes level, it sends a four-byte ASCII service-request frame over a byte-wide valid/ready transmit port. The frame is '!', then the unit address as two decimal digits, then a carriage return. Frames go out whether the unit is in local or remote control, because no mode input gates them. At most one further request waits while a frame is in flight, so a burst of changes during a frame yields exactly one follow-up frame.

The sender is a five-state machine:

| State | Role |
|---|---|
| SQ_IDLE | Waits for a pending request |
| SQ_BANG | Drives '!' |
| SQ_TENS | Drives the tens digit |
| SQ_ONES | Drives the ones digit |
| SQ_CR | Drives carriage return 0x0D |

The transitions are:
- SQ_IDLE to SQ_BANG when a request is pending. The address digits are latched on this transition.
- SQ_BANG to SQ_TENS, SQ_TENS to SQ_ONES, SQ_ONES to SQ_CR and SQ_CR to SQ_IDLE, each on a cycle where the byte is accepted (tx_ready_i high).
- Each state stays put while tx_ready_i is low.

Top module: `fault_srq_top`

## Requirements
- R1: After reset, evt_data_o is 0x00 and tx_valid_o is 0.
- R2: An event bit sets when its condition input is 1 and the matching enable bit is 1. It is visible on evt_data_o two rising edges after the condition input changes. The bit positions are: 0 spare, 1 mains failure, 2 over-temperature, 3 foldback, 4 over-voltage, 5 shut-off, 6 output off, 7 enable.
- R3: An event bit stays set after its condition input returns to 0.
- R4: A condition bit whose enable bit is 0 never sets its event bit.
- R5: While evt_rd_i is high, evt_data_o shows the event register. One edge later the register is cleared, except for bits set again in that cycle.
- R6: A clr_i pulse clears the whole event register.
- R7: If a fault is set in the same cycle as a read or clear, the set wins and the bit remains 1.
- R8: A change in any enabled condition bit produces a frame of four bytes: 0x21, the ASCII tens digit of addr_i, the ASCII ones digit, and 0x0D. Addresses above 99 are sent as 99.
- R9: With an enable mask of 0x00, or for changes only in disabled bits, no frame is sent.
- R10: A byte is held on tx_data_o, with tx_valid_o high, until tx_ready_i is 1 at a rising edge.
- R11: Any number of enabled changes during a frame in progress cause exactly one further frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| cond_i | input | 8 | Fault condition lines |
| mask_wr_i | input | 1 | Enable mask write strobe |
| mask_data_i | input | 8 | Enable mask write value |
| evt_rd_i | input | 1 | Event register read-and-clear strobe |
| clr_i | input | 1 | Clear-status strobe |
| addr_i | input | 7 | Unit address, 0 to 99 |
| evt_data_o | output | 8 | Event register value |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_data_o | output | 8 | Transmit byte |
| tx_ready_i | input | 1 | Transmit byte accepted |

## Verification
A change on cond_i reaches evt_data_o two rising edges later. The first frame byte appears three edges after the change, and each later byte follows one edge after the previous one is accepted. The bench drives its inputs 1 ns after a rising edge and samples at the falling edge. Event checks wait at least three cycles after a stimulus. Frame checks wait a fixed window that is longer than a full four-byte frame before counting the bytes collected at falling edges where valid and ready were both high.

// File: rtl/fault_srq_pkg.sv
package fault_srq_pkg;
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_BANG,
        SQ_TENS,
        SQ_ONES,
        SQ_CR
    } sq_state_e;

    localparam logic [7:0] CH_BANG = 8'h21;
    localparam logic [7:0] CH_CR   = 8'h0D;
    localparam logic [7:0] CH_ZERO = 8'h30;

    function automatic logic [7:0] to_ascii(input int unsigned d);
        return 8'(32'(CH_ZERO) + d);
    endfunction
endpackage

// File: rtl/flt_capture.sv
module flt_capture #(
    parameter int FLT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FLT_W-1:0] cond_i,
    input  logic             mask_wr_i,
    input  logic [FLT_W-1:0] mask_data_i,
    input  logic             rd_i,
    input  logic             clr_i,
    output logic [FLT_W-1:0] evt_o,
    output logic             change_o
);
    logic [FLT_W-1:0] cond_q, cond_prev_q, mask_q, evt_q;
    logic [FLT_W-1:0] hits, base;

    always_comb begin
        hits = cond_q & mask_q;
        base = (rd_i || clr_i) ? '0 : evt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cond_q      <= '0;
            cond_prev_q <= '0;
            mask_q      <= '0;
            evt_q       <= '0;
        end else begin
            cond_q      <= cond_i;
            cond_prev_q <= cond_q;
            if (mask_wr_i) mask_q <= mask_data_i;
            evt_q       <= base | hits;
        end
    end

    assign evt_o    = evt_q;
    assign change_o = |((cond_q ^ cond_prev_q) & mask_q);

    // R3: without a clear, no set bit drops
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_i || clr_i) |=> ((evt_q & $past(evt_q)) == $past(evt_q)));
    // R4: newly set bits are always enabled bits
    a_r4_masked: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((evt_q & ~$past(evt_q) & ~$past(mask_q)) == '0));
    // R6: clear with no live hit empties the register
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && hits == '0) |=> evt_q == '0);
    // R7: a live hit survives a simultaneous clear
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i || clr_i) |=> ((evt_q & $past(hits)) == $past(hits)));
endmodule

// File: rtl/addr_digits.sv
module addr_digits #(
    parameter int ADDR_W   = 7,
    parameter int ADDR_MAX = 99
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [7:0]        tens_o,
    output logic [7:0]        ones_o
);
    import fault_srq_pkg::*;

    int unsigned clamped;

    always_comb begin
        clamped = 32'(addr_i);
        if (clamped > ADDR_MAX) clamped = ADDR_MAX;
        tens_o = to_ascii(clamped / 10);
        ones_o = to_ascii(clamped % 10);
    end
endmodule

// File: rtl/srq_sender.sv
module srq_sender (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       change_i,
    input  logic [7:0] tens_i,
    input  logic [7:0] ones_i,
    input  logic       tx_ready_i,
    output logic       tx_valid_o,
    output logic [7:0] tx_data_o
);
    import fault_srq_pkg::*;

    sq_state_e  state_q, state_d;
    logic       pend_q, pend_d;
    logic [7:0] tens_q, ones_q;

    always_comb begin
        state_d = state_q;
        pend_d  = change_i | (pend_q & (state_q != SQ_IDLE));
        unique case (state_q)
            SQ_IDLE: if (pend_q)     state_d = SQ_BANG;
            SQ_BANG: if (tx_ready_i) state_d = SQ_TENS;
            SQ_TENS: if (tx_ready_i) state_d = SQ_ONES;
            SQ_ONES: if (tx_ready_i) state_d = SQ_CR;
            SQ_CR:   if (tx_ready_i) state_d = SQ_IDLE;
            default:                 state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            pend_q  <= 1'b0;
            tens_q  <= CH_ZERO;
            ones_q  <= CH_ZERO;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            if (state_q == SQ_IDLE && pend_q) begin
                tens_q <= tens_i;
                ones_q <= ones_i;
            end
        end
    end

    always_comb begin
        tx_valid_o = 1'b1;
        unique case (state_q)
            SQ_IDLE: begin tx_valid_o = 1'b0; tx_data_o = 8'h00; end
            SQ_BANG: tx_data_o = CH_BANG;
            SQ_TENS: tx_data_o = tens_q;
            SQ_ONES: tx_data_o = ones_q;
            SQ_CR:   tx_data_o = CH_CR;
            default: begin tx_valid_o = 1'b0; tx_data_o = 8'h00; end
        endcase
    end

    // R10: stalled byte is held
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));
    // R8: every frame opens with '!'
    a_r8_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid_o) |-> tx_data_o == CH_BANG);
    // R8: ones byte is a decimal digit
    a_r8_digit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_ONES) |-> (tx_data_o >= 8'h30 && tx_data_o <= 8'h39));
    // R11: a pending request is kept while a frame runs
    a_r11_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && state_q != SQ_IDLE) |=> pend_q);
endmodule

// File: rtl/fault_srq_top.sv
module fault_srq_top #(
    parameter int FLT_W    = 8,
    parameter int ADDR_W   = 7,
    parameter int ADDR_MAX = 99
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLT_W-1:0]  cond_i,
    input  logic              mask_wr_i,
    input  logic [FLT_W-1:0]  mask_data_i,
    input  logic              evt_rd_i,
    input  logic              clr_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [FLT_W-1:0]  evt_data_o,
    output logic              tx_valid_o,
    output logic [7:0]        tx_data_o,
    input  logic              tx_ready_i
);
    logic       change;
    logic [7:0] tens, ones;

    flt_capture #(.FLT_W(FLT_W)) u_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .cond_i      (cond_i),
        .mask_wr_i   (mask_wr_i),
        .mask_data_i (mask_data_i),
        .rd_i        (evt_rd_i),
        .clr_i       (clr_i),
        .evt_o       (evt_data_o),
        .change_o    (change)
    );

    addr_digits #(.ADDR_W(ADDR_W), .ADDR_MAX(ADDR_MAX)) u_digits (
        .addr_i (addr_i),
        .tens_o (tens),
        .ones_o (ones)
    );

    srq_sender u_sender (
        .clk        (clk),
        .rst_n      (rst_n),
        .change_i   (change),
        .tens_i     (tens),
        .ones_i     (ones),
        .tx_ready_i (tx_ready_i),
        .tx_valid_o (tx_valid_o),
        .tx_data_o  (tx_data_o)
    );

    // R1: idle transmit port out of reset
    a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !tx_valid_o);
endmodule

// File: tb/test_fault_srq_top.sv
module test_fault_srq_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cond_i = '0;
    logic       mask_wr_i = 1'b0;
    logic [7:0] mask_data_i = '0;
    logic       evt_rd_i = 1'b0;
    logic       clr_i = 1'b0;
    logic [6:0] addr_i = 7'd37;
    logic [7:0] evt_data_o;
    logic       tx_valid_o;
    logic [7:0] tx_data_o;
    logic       tx_ready_i = 1'b1;

    int checks = 0;
    int fails = 0;
    int rx_n = 0;
    logic [7:0] rx_b [0:63];

    always #5 clk = ~clk;

    fault_srq_top i_fault_srq_top (
        .clk(clk), .rst_n(rst_n), .cond_i(cond_i), .mask_wr_i(mask_wr_i),
        .mask_data_i(mask_data_i), .evt_rd_i(evt_rd_i), .clr_i(clr_i),
        .addr_i(addr_i), .evt_data_o(evt_data_o), .tx_valid_o(tx_valid_o),
        .tx_data_o(tx_data_o), .tx_ready_i(tx_ready_i)
    );

    always @(negedge clk) begin
        if (rst_n && tx_valid_o && tx_ready_i && rx_n < 64) begin
            rx_b[rx_n] = tx_data_o;
            rx_n = rx_n + 1;
        end
    end

    typedef struct packed {
        logic [7:0] mask;
        logic [7:0] cond;
        logic [7:0] evt;
        logic [7:0] nbytes;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{8'hFF, 8'h02, 8'h02, 8'd4},
        '{8'h00, 8'hFF, 8'h00, 8'd0},
        '{8'h7E, 8'h81, 8'h00, 8'd0},
        '{8'h81, 8'h81, 8'h81, 8'd4},
        '{8'hF0, 8'h3C, 8'h30, 8'd4},
        '{8'h0F, 8'h3C, 8'h0C, 8'd4},
        '{8'h40, 8'h40, 8'h40, 8'd4},
        '{8'hFE, 8'h01, 8'h00, 8'd0}
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic write_mask(input logic [7:0] m);
        mask_data_i = m; mask_wr_i = 1'b1;
        tick(1);
        mask_wr_i = 1'b0;
    endtask

    task automatic pulse_clr();
        clr_i = 1'b1; tick(1); clr_i = 1'b0;
    endtask

    task automatic check_frame(input int base, input logic [7:0] t, input logic [7:0] o, input string req);
        check(req, rx_b[base],   8'h21);
        check(req, rx_b[base+1], t);
        check(req, rx_b[base+2], o);
        check(req, rx_b[base+3], 8'h0D);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        tick(3);
        @(negedge clk);
        check("R1 evt", 32'(evt_data_o), 0);
        check("R1 valid", 32'(tx_valid_o), 0);
        rst_n = 1'b1;
        tick(2);
        @(negedge clk);
        check("R1 evt after release", 32'(evt_data_o), 0);

        // table walk: R2 R4 R9
        for (int i = 0; i < 8; i++) begin
            cond_i = '0;
            tick(12);
            write_mask(VECS[i].mask);
            pulse_clr();
            tick(2);
            rx_n = 0;
            cond_i = VECS[i].cond;
            tick(14);
            @(negedge clk);
            check("R2/R4 table evt", 32'(evt_data_o), 32'(VECS[i].evt));
            check("R9 table frame bytes", rx_n, 32'(VECS[i].nbytes));
            if (VECS[i].nbytes == 8'd4) check_frame(0, 8'h33, 8'h37, "R8 frame");
        end

        // R3 sticky
        cond_i = '0; tick(12); write_mask(8'hFF); pulse_clr();
        cond_i = 8'h10; tick(3);
        cond_i = 8'h00; tick(4);
        @(negedge clk);
        check("R3 sticky", 32'(evt_data_o), 32'h10);

        // R5 read and clear
        @(posedge clk); #1;
        evt_rd_i = 1'b1;
        @(negedge clk);
        check("R5 read value", 32'(evt_data_o), 32'h10);
        tick(1);
        evt_rd_i = 1'b0;
        @(negedge clk);
        check("R5 cleared", 32'(evt_data_o), 0);

        // R6 clear-status
        cond_i = 8'h08; tick(3); cond_i = 8'h00; tick(3);
        pulse_clr();
        @(negedge clk);
        check("R6 clear", 32'(evt_data_o), 0);

        // R7 set wins over clear and read
        cond_i = 8'h04; tick(4);
        pulse_clr();
        @(negedge clk);
        check("R7 set wins clr", 32'(evt_data_o), 32'h04);
        @(posedge clk); #1;
        evt_rd_i = 1'b1; tick(1); evt_rd_i = 1'b0;
        @(negedge clk);
        check("R7 set wins rd", 32'(evt_data_o), 32'h04);
        cond_i = 8'h00; tick(12);

        // R10 handshake stall
        rx_n = 0;
        tx_ready_i = 1'b0;
        cond_i = 8'h20;
        tick(4);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check("R10 held valid", 32'(tx_valid_o), 1);
            check("R10 held data", 32'(tx_data_o), 32'h21);
        end
        check("R10 nothing taken", rx_n, 0);

        // R11 merge: toggles while stalled
        @(posedge clk); #1;
        cond_i = 8'h00; tick(2);
        cond_i = 8'h20; tick(2);
        cond_i = 8'h00; tick(3);
        tx_ready_i = 1'b1;
        tick(20);
        @(negedge clk);
        check("R11 two frames", rx_n, 8);
        check_frame(0, 8'h33, 8'h37, "R11 first");
        check_frame(4, 8'h33, 8'h37, "R11 second");

        // R8 address edge values
        rx_n = 0; addr_i = 7'd120;
        cond_i = 8'h02; tick(14);
        @(negedge clk);
        check("R8 clamp bytes", rx_n, 4);
        check_frame(0, 8'h39, 8'h39, "R8 clamp");
        rx_n = 0; addr_i = 7'd5;
        cond_i = 8'h00; tick(14);
        @(negedge clk);
        check("R8 low addr bytes", rx_n, 4);
        check_frame(0, 8'h30, 8'h35, "R8 low addr");

        // R9 disabled-bit change
        rx_n = 0; write_mask(8'h01);
        cond_i = 8'hFE; tick(14);
        @(negedge clk);
        check("R9 disabled change", rx_n, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule